// File: doc/BRIEF.md
# Base-Index-Displacement Address Generator

This block turns one instruction of a two-address instruction set into the operand storage addresses it needs. The instruction arrives left-justified in a 48-bit word, with its first byte (the opcode) in the top bits. The block decodes the format class from the opcode. It then reads up to two general registers through combinational read ports of an external 16-entry, 32-bit register file. It adds base, optional index and a zero-extended 12-bit displacement, and keeps the low 24 bits of the sum as the effective address.

The same 4-bit slot in the second byte means different things in different formats. In the register-indexed format it is an index register. In the register-storage format it is the end register of a multi-register transfer and is passed out without being added. Storage-to-storage instructions carry a second base and displacement pair, which produces a second address. The instruction input and the result output each use a valid/ready handshake. Results are registered and appear in the cycle after acceptance.

Top module: `agen_top`

## Requirements
- R1: `fmt_o` reports the format class decoded from opcode bits [7:6] (insn bits [47:46]): 00 gives RR=0, 01 gives RX=1, 11 gives SS=4, and 10 gives RS=2 when opcode bit 5 is 0 or SI=3 when it is 1.
- R2: `ilen_o` reports the instruction length in bytes: 2 for RR, 4 for RX, RS and SI, 6 for SS.
- R3: For RX, RS, SI and SS, `ea1_o` equals base(B1) + index + D1, where B1 is insn[31:28] and D1 = insn[27:16] is zero-extended. The index is the register selected by X = insn[35:32] in RX only, and zero in all other formats.
- R4: A B or X field equal to 0 contributes zero to the sum, whatever register 0 holds.
- R5: In RS, the field insn[35:32] is not added to the address and is output on `r2_o` as the end register. In RX, `r2_o` is 0.
- R6: RR produces `ea1_o`=`ea2_o`=0, with `r1_o`=insn[39:36] as destination and `r2_o`=insn[35:32]. `r1_o` carries insn[39:36] in RR, RX and RS, and is 0 in SI and SS.
- R7: SS produces `ea2_o` = base(B2) + D2, where B2 is insn[15:12] and D2 = insn[11:0]. `byte1_o` carries insn[39:32] unchanged in SI (immediate) and SS (length), and is 0 otherwise. `ea2_o` is 0 in every format but SS.
- R8: Address sums wrap modulo 2^24. Only the low 24 bits of the 32-bit sum are kept.
- R9: An instruction accepted on a clock edge (`in_valid_i` and `in_ready_o` high) is presented with `out_valid_o` high after that edge. Reset leaves `out_valid_o` low and `in_ready_o` high.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is low and every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction present |
| in_ready_o | output | 1 | Instruction can be taken |
| insn_i | input | 48 | Instruction, first byte in [47:40] |
| rd_addr_a_o | output | 4 | Register read port A select (first base) |
| rd_data_a_i | input | 32 | Register read port A data |
| rd_addr_b_o | output | 4 | Register read port B select (index or second base) |
| rd_data_b_i | input | 32 | Register read port B data |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Result taken by consumer |
| fmt_o | output | 3 | Format class code |
| ilen_o | output | 3 | Instruction length in bytes |
| r1_o | output | 4 | First register specifier |
| r2_o | output | 4 | Second register specifier or end register |
| byte1_o | output | 8 | Immediate byte or storage-to-storage length |
| ea1_o | output | 24 | First effective address |
| ea2_o | output | 24 | Second effective address |

## Verification
Two things can happen in the same cycle. The consumer can take a result while the block accepts the next instruction, and the block can then reload its output register in place. The bench holds `out_ready_i` high under continuous instruction traffic to force back-to-back handoffs. Later it mixes in random ready drops, so that stalls fall on every format. A behavioural model tracks acceptance and occupancy and computes each expected result from its own register copy. The model is compared against every output on every clock, so a lost, duplicated or overwritten result shows as a mismatch in that cycle. Directed cases cover zero fields with a nonzero register 0, the same register used as both base and index, and sums that cross 2^24.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned INSN_W = 48;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned DISP_W = 12;
  localparam int unsigned FMT_W  = 3;
  localparam int unsigned LEN_W  = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_RR = 3'd0,
    FMT_RX = 3'd1,
    FMT_RS = 3'd2,
    FMT_SI = 3'd3,
    FMT_SS = 3'd4
  } fmt_e;

  function automatic fmt_e fmt_of(input logic [7:0] op);
    unique case (op[7:6])
      2'b00:   fmt_of = FMT_RR;
      2'b01:   fmt_of = FMT_RX;
      2'b10:   fmt_of = op[5] ? FMT_SI : FMT_RS;
      default: fmt_of = FMT_SS;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input fmt_e f);
    unique case (f)
      FMT_RR:  len_of = 3'd2;
      FMT_SS:  len_of = 3'd6;
      default: len_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/agen_decode.sv
module agen_decode
  import agen_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output fmt_e              fmt_o,
  output logic [LEN_W-1:0]  ilen_o,
  output logic [SEL_W-1:0]  b1_o,
  output logic [DISP_W-1:0] d1_o,
  output logic [SEL_W-1:0]  b2_o,
  output logic [DISP_W-1:0] d2_o,
  output logic [SEL_W-1:0]  x_o,
  output logic              use_x_o,
  output logic              use_op1_o,
  output logic              use_op2_o,
  output logic [SEL_W-1:0]  r1_o,
  output logic [SEL_W-1:0]  r2_o,
  output logic [7:0]        byte1_o
);
  localparam int unsigned OP_HI = INSN_W - 1;
  localparam int unsigned B1_HI = OP_HI - 8;
  localparam int unsigned F1_HI = B1_HI - 8;
  localparam int unsigned D1_HI = F1_HI - SEL_W;
  localparam int unsigned F2_HI = D1_HI - DISP_W;
  localparam int unsigned D2_HI = F2_HI - SEL_W;

  logic [7:0] op, b1_byte;

  assign op      = insn_i[OP_HI -: 8];
  assign b1_byte = insn_i[B1_HI -: 8];
  assign b1_o    = insn_i[F1_HI -: SEL_W];
  assign d1_o    = insn_i[D1_HI -: DISP_W];
  assign b2_o    = insn_i[F2_HI -: SEL_W];
  assign d2_o    = insn_i[D2_HI -: DISP_W];
  assign x_o     = b1_byte[3:0];

  always_comb begin
    fmt_o     = fmt_of(op);
    ilen_o    = len_of(fmt_o);
    use_x_o   = (fmt_o == FMT_RX);
    use_op1_o = (fmt_o != FMT_RR);
    use_op2_o = (fmt_o == FMT_SS);
    r1_o      = '0;
    r2_o      = '0;
    byte1_o   = '0;
    unique case (fmt_o)
      FMT_RR: begin r1_o = b1_byte[7:4]; r2_o = b1_byte[3:0]; end
      FMT_RX: r1_o = b1_byte[7:4];
      FMT_RS: begin r1_o = b1_byte[7:4]; r2_o = b1_byte[3:0]; end
      FMT_SI, FMT_SS: byte1_o = b1_byte;
      default: ;
    endcase
  end
endmodule

// File: rtl/agen_ea.sv
module agen_ea
  import agen_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              en_i,
  input  logic [SEL_W-1:0]  base_sel_i,
  input  logic [REG_W-1:0]  base_val_i,
  input  logic              idx_en_i,
  input  logic [SEL_W-1:0]  idx_sel_i,
  input  logic [REG_W-1:0]  idx_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [REG_W-1:0] base_c, idx_c, disp_c, sum;

  // selector 0 means "no register", not register 0
  assign base_c = (base_sel_i == '0) ? '0 : base_val_i;
  assign idx_c  = (!idx_en_i || idx_sel_i == '0) ? '0 : idx_val_i;
  assign disp_c = {{(REG_W-DISP_W){1'b0}}, disp_i};
  assign sum    = base_c + idx_c + disp_c;
  assign ea_o   = en_i ? sum[ADDR_W-1:0] : '0;
endmodule

// File: rtl/agen_out_reg.sv
module agen_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      q_o         <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (in_valid_i && in_ready_o) q_o <= d_i;
    end
  end

  p_accept_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_stall_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(q_o)));
endmodule

// File: rtl/agen_top.sv
module agen_top
  import agen_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [INSN_W-1:0] insn_i,
  output logic [SEL_W-1:0]  rd_addr_a_o,
  input  logic [REG_W-1:0]  rd_data_a_i,
  output logic [SEL_W-1:0]  rd_addr_b_o,
  input  logic [REG_W-1:0]  rd_data_b_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [FMT_W-1:0]  fmt_o,
  output logic [LEN_W-1:0]  ilen_o,
  output logic [SEL_W-1:0]  r1_o,
  output logic [SEL_W-1:0]  r2_o,
  output logic [7:0]        byte1_o,
  output logic [ADDR_W-1:0] ea1_o,
  output logic [ADDR_W-1:0] ea2_o
);
  localparam int unsigned N_OPS = 2;
  localparam int unsigned RES_W = FMT_W + LEN_W + 2*SEL_W + 8 + N_OPS*ADDR_W;

  fmt_e              fmt;
  logic [LEN_W-1:0]  ilen;
  logic [SEL_W-1:0]  b1, b2, x, r1, r2;
  logic [DISP_W-1:0] d1, d2;
  logic [7:0]        byte1;
  logic              use_x, use_op1, use_op2;

  agen_decode u_dec (
    .insn_i   (insn_i),
    .fmt_o    (fmt),
    .ilen_o   (ilen),
    .b1_o     (b1),
    .d1_o     (d1),
    .b2_o     (b2),
    .d2_o     (d2),
    .x_o      (x),
    .use_x_o  (use_x),
    .use_op1_o(use_op1),
    .use_op2_o(use_op2),
    .r1_o     (r1),
    .r2_o     (r2),
    .byte1_o  (byte1)
  );

  // port A: first base; port B: index (RX) or second base (SS)
  assign rd_addr_a_o = use_op1 ? b1 : '0;
  assign rd_addr_b_o = use_x ? x : (use_op2 ? b2 : '0);

  logic [ADDR_W-1:0] ea [N_OPS];
  logic              op_en   [N_OPS];
  logic [SEL_W-1:0]  op_bsel [N_OPS];
  logic [REG_W-1:0]  op_bval [N_OPS];
  logic [DISP_W-1:0] op_disp [N_OPS];
  logic              op_xen  [N_OPS];

  assign op_en[0]   = use_op1;
  assign op_bsel[0] = b1;
  assign op_bval[0] = rd_data_a_i;
  assign op_disp[0] = d1;
  assign op_xen[0]  = use_x;
  assign op_en[1]   = use_op2;
  assign op_bsel[1] = b2;
  assign op_bval[1] = rd_data_b_i;
  assign op_disp[1] = d2;
  assign op_xen[1]  = 1'b0;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    agen_ea #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ea (
      .en_i      (op_en[g]),
      .base_sel_i(op_bsel[g]),
      .base_val_i(op_bval[g]),
      .idx_en_i  (op_xen[g]),
      .idx_sel_i (x),
      .idx_val_i (rd_data_b_i),
      .disp_i    (op_disp[g]),
      .ea_o      (ea[g])
    );
  end

  logic [RES_W-1:0] res_d, res_q;
  assign res_d = {fmt, ilen, r1, r2, byte1, ea[0], ea[1]};

  agen_out_reg #(.W(RES_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .d_i        (res_d),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .q_o        (res_q)
  );

  assign {fmt_o, ilen_o, r1_o, r2_o, byte1_o, ea1_o, ea2_o} = res_q;

  p_rr_noaddr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && fmt_o == FMT_RR) |-> (ea1_o == '0 && ea2_o == '0));

  p_len_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (ilen_o == ((fmt_o == FMT_RR) ? 3'd2 : (fmt_o == FMT_SS) ? 3'd6 : 3'd4)));

  p_ea2_ss_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && fmt_o != FMT_SS) |-> (ea2_o == '0));
endmodule

// File: tb/agen_top_bench.sv
module agen_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] insn = '0;
  logic [3:0]  ra, rb;
  logic [31:0] rda, rdb;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  fmt, ilen;
  logic [3:0]  r1, r2;
  logic [7:0]  byte1;
  logic [23:0] ea1, ea2;

  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] rf [16];
  assign rda = rf[ra];
  assign rdb = rf[rb];

  agen_top u_agen_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .insn_i(insn), .rd_addr_a_o(ra), .rd_data_a_i(rda), .rd_addr_b_o(rb),
    .rd_data_b_i(rdb), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .fmt_o(fmt), .ilen_o(ilen), .r1_o(r1), .r2_o(r2), .byte1_o(byte1),
    .ea1_o(ea1), .ea2_o(ea2)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [47:0] insn_q [$];

  // behavioural reference
  logic        m_valid = 1'b0;
  logic [2:0]  m_fmt, m_ilen;
  logic [3:0]  m_r1, m_r2;
  logic [7:0]  m_b1;
  logic [23:0] m_ea1, m_ea2;
  logic        acc_last = 1'b0;

  function automatic logic [31:0] rv(input logic [3:0] s);
    return (s == 0) ? 32'd0 : rf[s];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      acc_last <= 1'b0;
    end else begin
      logic acc;
      logic [7:0] op, b;
      logic [2:0] f;
      logic [31:0] s;
      acc = in_valid && (!m_valid || out_ready);
      acc_last <= acc;
      if (!m_valid || out_ready) m_valid <= in_valid;
      if (acc) begin
        op = insn[47:40]; b = insn[39:32];
        f = (op[7:6] == 0) ? 3'd0 : (op[7:6] == 1) ? 3'd1 : (op[7:6] == 3) ? 3'd4 : (op[5] ? 3'd3 : 3'd2);
        m_fmt  <= f;
        m_ilen <= (f == 0) ? 3'd2 : (f == 4) ? 3'd6 : 3'd4;
        m_r1   <= (f <= 2) ? b[7:4] : 4'd0;
        m_r2   <= (f == 0 || f == 2) ? b[3:0] : 4'd0;
        m_b1   <= (f >= 3) ? b : 8'd0;
        s = rv(insn[31:28]) + ((f == 1) ? rv(b[3:0]) : 32'd0) + {20'd0, insn[27:16]};
        m_ea1  <= (f == 0) ? 24'd0 : s[23:0];
        s = rv(insn[15:12]) + {20'd0, insn[11:0]};
        m_ea2  <= (f == 4) ? s[23:0] : 24'd0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      check("R9 out_valid", out_valid, m_valid);
      check("R10 in_ready", in_ready, !m_valid || out_ready);
      if (m_valid && out_valid) begin
        check("R1 fmt", fmt, m_fmt);
        check("R2 ilen", ilen, m_ilen);
        check("R3/R4/R8 ea1", ea1, m_ea1);
        check("R7 ea2", ea2, m_ea2);
        check("R6 r1", r1, m_r1);
        check("R5/R6 r2", r2, m_r2);
        check("R7 byte1", byte1, m_b1);
      end
      #1;
      if (acc_last || !in_valid) begin
        if (insn_q.size() > 0) begin
          insn = insn_q.pop_front();
          in_valid = 1'b1;
        end else in_valid = 1'b0;
      end
      out_ready = (cyc < 30) ? 1'b1 : ($urandom % 4 != 0);
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    rf[0]  = 32'hDEAD_BEEF;  // R4: must never be used
    rf[3]  = 32'h0012_3000;
    rf[5]  = 32'h0000_0400;
    rf[14] = 32'hFFFF_FFF0;  // R8 wrap
    rf[15] = 32'h00FF_FFFF;
    insn_q.push_back(48'h1A35_0000_0000);   // R6 RR
    insn_q.push_back(48'h4A05_0123_0000);   // R3/R4 RX base 0, X=5
    insn_q.push_back(48'h4A00_3456_0000);   // R4 RX X=0
    insn_q.push_back(48'h4A00_0FFF_0000);   // R4 both zero
    insn_q.push_back(48'h4A33_3010_0000);   // R3 base==index
    insn_q.push_back(48'h5000_E020_0000);   // R8 wrap base
    insn_q.push_back(48'h4AEF_F001_0000);   // R8 wrap base+index
    insn_q.push_back(48'h9027_5008_0000);   // R5 RS, R3 not added
    insn_q.push_back(48'hA5C3_3100_0000);   // R7 SI immediate
    insn_q.push_back(48'hD2FF_3010_0FFF);   // R7 SS, base2 0
    insn_q.push_back(48'hD280_E7FF_F002);   // R7/R8 SS wrap
    for (int i = 0; i < 400; i++) insn_q.push_back({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
    repeat (3) @(posedge clk);
    // R9 reset state
    #2;
    check("R9 reset out_valid", out_valid, 0);
    check("R9 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    while ((insn_q.size() > 0 || in_valid || m_valid) && cyc < 20000) @(posedge clk);
    if (cyc >= 20000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
    end
    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule